// File: doc/BRIEF.md
# DRAM chip-select window decoder

This block sits between the CPU's physical address and the DRAM controller. It holds a small set of base/size windows. For every CPU address it reports which DRAM chip select owns that address, together with the bus attribute that a device must use to reach it and a hit flag. Windows are programmed through a plain 32-bit register write/read port. Each lookup result is registered, so it appears one clock after the address is presented.

A static parameter picks one of two configuration styles. The split style has four windows, each with its own base register and size register. The base can reach above 4 GiB, and a chip-select number is chosen per window. The packed style has two windows, each held in one map register with a log-encoded size. In this style the chip select is the window index and the attribute is zero. In both styles the block also exports a summary of windows that DMA devices can use: the enabled windows whose base lies below 4 GiB, given as a count and as an ascending list of window indices.

Top module: `dcs_decoder`

## Requirements
- R1: After synchronous reset, every window is disabled, every register reads zero, `dram_hit`, `dram_cs` and `dram_attr` are zero, and `usable_cnt` and `usable_list` are zero.
- R2: In split style, window n has its base register at byte offset 8·n and its size register at 8·n+4, for n = 0..3. Bits other than base bits 31:24 and 3:0, and size bits 31:24, 4:2 and 0, read as zero. Writes and reads at any other offset have no effect and return zero.
- R3: In split style, the window base is the address whose bits 35:32 come from base register bits 3:0 and whose bits 31:24 come from base register bits 31:24, with all lower bits zero. The size is ((size bits 31:24) · 2^24 + 0xFFFFFF) + 1. Size register bit 0 enables the window. An address hits the window when base ≤ address < base + size.
- R4: When several enabled windows contain the address, the window with the lowest index wins.
- R5: `dram_cs` is eight bits wide. On a hit it is one-hot, with the bit set at the chip-select number of the winning window. In split style that number is size register bits 4:2; in packed style it is the window index. On a miss, `dram_hit`, `dram_cs` and `dram_attr` are all zero.
- R6: In split style, bits 3:0 of the attribute for window i are 0xF with bit i cleared. Attribute bit 4 equals `coherent_en` as sampled with the address.
- R7: `dram_hit`, `dram_cs` and `dram_attr` reflect the `cpu_addr` and `coherent_en` present at the previous rising clock edge. A register write takes effect for lookups sampled from the next edge onward.
- R8: A window is usable when it is enabled and its base bits 35:32 are zero. `usable_cnt` gives the number of usable windows. `usable_list` holds their 2-bit indices in ascending order: the k-th usable window sits at bits 2k+1:2k, and unused slots are zero.
- R9: In packed style, map register n is at offset 16·n, for n = 0..1. Bit 0 enables the window, bits 31:23 give address bits 31:23 of the base (bits 35:32 are zero), and bits 19:16 hold a value f that sets the size to 2^(f+16) bytes. All other bits read zero, other offsets are ignored, and the attribute is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| coherent_en | input | 1 | Request the hardware-coherency attribute bit |
| cpu_addr | input | 36 | CPU physical address to decode |
| dram_hit | output | 1 | Registered: address fell in an enabled window |
| dram_cs | output | 8 | Registered one-hot chip select |
| dram_attr | output | 5 | Registered bus attribute of the winning window |
| usable_cnt | output | 3 | Number of device-usable windows |
| usable_list | output | 8 | Ascending indices of device-usable windows, 2 bits each |

## Verification
A corrupted window register shows up in two places. The register reads it back wrongly at once, and lookups near its edges (base, base + size − 1, base + size) hit the wrong chip select one cycle after the address is applied. A broken priority or compare appears only where windows overlap or at a bound, so the test places addresses exactly on each edge and inside a deliberate overlap. The usable summary follows the registers with no delay, so a bad enable or high-base decode shows up in the count and list as soon as the write lands.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int CFG_AW   = 8;
    localparam int DATA_W   = 32;
    localparam int PA_W     = 36;
    localparam int MAX_WIN  = 4;
    localparam int PACK_WIN = 2;
    localparam int IDX_W    = $clog2(MAX_WIN);
    localparam int CSN_W    = 3;
    localparam int NCS      = 1 << CSN_W;
    localparam int ATTR_W   = 5;
    localparam int CNT_W    = $clog2(MAX_WIN + 1);
    localparam int LIST_W   = MAX_WIN * IDX_W;

    localparam logic [DATA_W-1:0] SPLIT_BASE_MASK = 32'hFF00_000F;
    localparam logic [DATA_W-1:0] SPLIT_SIZE_MASK = 32'hFF00_001D;
    localparam logic [DATA_W-1:0] PACK_MAP_MASK   = 32'hFF8F_0001;

    typedef struct packed {
        logic             en;
        logic             usable;
        logic [PA_W-1:0]  base;
        logic [PA_W:0]    lim;
        logic [CSN_W-1:0] csn;
    } win_t;

    function automatic win_t split_decode(logic [DATA_W-1:0] b, logic [DATA_W-1:0] s);
        win_t          w;
        logic [PA_W:0] span;
        w.en     = s[0];
        w.base   = {b[3:0], b[31:24], 24'h0};
        span     = {5'h0, s[31:24], 24'hFF_FFFF} + 37'd1;
        w.lim    = {1'b0, w.base} + span;
        w.csn    = s[4:2];
        w.usable = s[0] && (b[3:0] == 4'h0);
        return w;
    endfunction

    function automatic win_t packed_decode(logic [DATA_W-1:0] m, logic [IDX_W-1:0] idx);
        win_t w;
        w.en     = m[0];
        w.base   = {4'h0, m[31:23], 23'h0};
        w.lim    = {1'b0, w.base} + (37'd1 << ({1'b0, m[19:16]} + 5'd16));
        w.csn    = CSN_W'(idx);
        w.usable = m[0];
        return w;
    endfunction

    function automatic logic [ATTR_W-1:0] win_attr(int idx, logic coh);
        logic [3:0] nib;
        nib      = 4'hF;
        nib[idx] = 1'b0;
        return {coh, nib};
    endfunction

    function automatic logic [NCS-1:0] cs_onehot(logic [CSN_W-1:0] csn);
        logic [NCS-1:0] v;
        v      = '0;
        v[csn] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
    import dcs_pkg::*;
#(
    parameter bit PACKED = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [CFG_AW-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output win_t [MAX_WIN-1:0]          wins
);
    if (PACKED) begin : g_pack
        logic [DATA_W-1:0] map_q [PACK_WIN];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int n = 0; n < PACK_WIN; n++) map_q[n] <= '0;
            end else if (we) begin
                for (int n = 0; n < PACK_WIN; n++)
                    if (addr == CFG_AW'(16 * n)) map_q[n] <= wdata & PACK_MAP_MASK;
            end
        end

        always_comb begin
            rdata = '0;
            for (int n = 0; n < PACK_WIN; n++)
                if (addr == CFG_AW'(16 * n)) rdata = map_q[n];
        end

        for (genvar i = 0; i < MAX_WIN; i++) begin : g_win
            if (i < PACK_WIN) begin : g_live
                assign wins[i] = packed_decode(map_q[i], IDX_W'(i));
            end else begin : g_off
                assign wins[i] = '0;
            end
        end
    end else begin : g_split
        logic [DATA_W-1:0] base_q [MAX_WIN];
        logic [DATA_W-1:0] size_q [MAX_WIN];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int n = 0; n < MAX_WIN; n++) begin
                    base_q[n] <= '0;
                    size_q[n] <= '0;
                end
            end else if (we) begin
                for (int n = 0; n < MAX_WIN; n++) begin
                    if (addr == CFG_AW'(8 * n))     base_q[n] <= wdata & SPLIT_BASE_MASK;
                    if (addr == CFG_AW'(8 * n + 4)) size_q[n] <= wdata & SPLIT_SIZE_MASK;
                end
            end
        end

        always_comb begin
            rdata = '0;
            for (int n = 0; n < MAX_WIN; n++) begin
                if (addr == CFG_AW'(8 * n))     rdata = base_q[n];
                if (addr == CFG_AW'(8 * n + 4)) rdata = size_q[n];
            end
        end

        for (genvar i = 0; i < MAX_WIN; i++) begin : g_win
            assign wins[i] = split_decode(base_q[i], size_q[i]);
        end
    end
endmodule

// File: rtl/dcs_match.sv
module dcs_match
    import dcs_pkg::*;
#(
    parameter bit PACKED = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  win_t [MAX_WIN-1:0]  wins,
    input  logic [PA_W-1:0]     addr,
    input  logic                coh,
    output logic                hit_q,
    output logic [NCS-1:0]      cs_q,
    output logic [ATTR_W-1:0]   attr_q
);
    logic [MAX_WIN-1:0] in_win;
    logic               hit_c;
    logic [NCS-1:0]     cs_c;
    logic [ATTR_W-1:0]  attr_c;

    for (genvar i = 0; i < MAX_WIN; i++) begin : g_cmp
        assign in_win[i] = wins[i].en && (addr >= wins[i].base) &&
                           ({1'b0, addr} < wins[i].lim);
    end

    always_comb begin
        hit_c  = 1'b0;
        cs_c   = '0;
        attr_c = '0;
        for (int i = MAX_WIN - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                hit_c  = 1'b1;
                cs_c   = cs_onehot(wins[i].csn);
                attr_c = PACKED ? '0 : win_attr(i, coh);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            cs_q   <= '0;
            attr_q <= '0;
        end else begin
            hit_q  <= hit_c;
            cs_q   <= cs_c;
            attr_q <= attr_c;
        end
    end
endmodule

// File: rtl/dcs_usable.sv
module dcs_usable
    import dcs_pkg::*;
(
    input  win_t [MAX_WIN-1:0] wins,
    output logic [CNT_W-1:0]   cnt,
    output logic [LIST_W-1:0]  list
);
    always_comb begin
        int slot;
        slot = 0;
        list = '0;
        for (int i = 0; i < MAX_WIN; i++) begin
            if (wins[i].usable) begin
                list[slot*IDX_W +: IDX_W] = IDX_W'(i);
                slot = slot + 1;
            end
        end
        cnt = CNT_W'(slot);
    end
endmodule

// File: rtl/dcs_decoder.sv
module dcs_decoder
    import dcs_pkg::*;
#(
    parameter bit PACKED_MODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic                coherent_en,
    input  logic [PA_W-1:0]     cpu_addr,
    output logic                dram_hit,
    output logic [NCS-1:0]      dram_cs,
    output logic [ATTR_W-1:0]   dram_attr,
    output logic [CNT_W-1:0]    usable_cnt,
    output logic [LIST_W-1:0]   usable_list
);
    win_t [MAX_WIN-1:0] wins;

    dcs_regs #(.PACKED(PACKED_MODE)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .wins  (wins)
    );

    dcs_match #(.PACKED(PACKED_MODE)) u_match (
        .clk    (clk),
        .rst    (rst),
        .wins   (wins),
        .addr   (cpu_addr),
        .coh    (coherent_en),
        .hit_q  (dram_hit),
        .cs_q   (dram_cs),
        .attr_q (dram_attr)
    );

    dcs_usable u_usable (
        .wins (wins),
        .cnt  (usable_cnt),
        .list (usable_list)
    );
endmodule

// File: rtl/dcs_decoder_chk.sv
module dcs_decoder_chk
    import dcs_pkg::*;
#(
    parameter bit PACKED_MODE = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic               coherent_en,
    input logic               dram_hit,
    input logic [NCS-1:0]     dram_cs,
    input logic [ATTR_W-1:0]  dram_attr,
    input logic [CNT_W-1:0]   usable_cnt,
    input logic [LIST_W-1:0]  usable_list
);
    localparam int NWIN = PACKED_MODE ? PACK_WIN : MAX_WIN;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!dram_hit && dram_cs == '0 && usable_cnt == '0)); // R1
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dram_cs)); // R5
    AST_HIT_HAS_CS: assert property (@(posedge clk) disable iff (rst)
        dram_hit |-> $countones(dram_cs) == 1); // R5
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dram_hit |-> (dram_cs == '0 && dram_attr == '0)); // R5
    AST_ATTR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (dram_hit && !PACKED_MODE) |-> $countones(dram_attr[3:0]) == 3); // R6
    AST_ATTR_COH: assert property (@(posedge clk) disable iff (rst)
        (dram_hit && !PACKED_MODE) |-> dram_attr[4] == $past(coherent_en)); // R7
    AST_PACK_ATTR: assert property (@(posedge clk) disable iff (rst)
        (dram_hit && PACKED_MODE) |-> dram_attr == '0); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        usable_cnt <= CNT_W'(NWIN)); // R8
    AST_LIST_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (usable_cnt >= CNT_W'(2)) |-> usable_list[2*IDX_W-1:IDX_W] > usable_list[IDX_W-1:0]); // R8
endmodule

bind dcs_decoder dcs_decoder_chk #(.PACKED_MODE(PACKED_MODE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .coherent_en (coherent_en),
    .dram_hit    (dram_hit),
    .dram_cs     (dram_cs),
    .dram_attr   (dram_attr),
    .usable_cnt  (usable_cnt),
    .usable_list (usable_list)
);

// File: tb/sim_dcs_decoder.sv
`timescale 1ns/1ps
module sim_dcs_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we0 = 1'b0, we1 = 1'b0;
    logic [7:0]  caddr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        coh = 1'b0;
    logic [35:0] a0 = '0, a1 = '0;
    logic        hit0, hit1;
    logic [7:0]  cs0, cs1;
    logic [4:0]  at0, at1;
    logic [2:0]  cnt0, cnt1;
    logic [7:0]  lst0, lst1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         dut;
        logic       hit;
        logic [7:0] cs;
        logic [4:0] attr;
        string      req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    dcs_decoder #(.PACKED_MODE(1'b0)) u0 (
        .clk(clk), .rst(rst), .cfg_we(we0), .cfg_addr(caddr), .cfg_wdata(wdata),
        .cfg_rdata(rd0), .coherent_en(coh), .cpu_addr(a0), .dram_hit(hit0),
        .dram_cs(cs0), .dram_attr(at0), .usable_cnt(cnt0), .usable_list(lst0));

    dcs_decoder #(.PACKED_MODE(1'b1)) u1 (
        .clk(clk), .rst(rst), .cfg_we(we1), .cfg_addr(caddr), .cfg_wdata(wdata),
        .cfg_rdata(rd1), .coherent_en(coh), .cpu_addr(a1), .dram_hit(hit1),
        .dram_cs(cs1), .dram_attr(at1), .usable_cnt(cnt1), .usable_list(lst1));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int dut, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        caddr = a; wdata = d;
        if (dut == 0) we0 = 1'b1; else we1 = 1'b1;
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic rd(int dut, logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        caddr = a;
        #1;
        chk(req, (dut == 0) ? rd0 : rd1, exp);
    endtask

    // driver: applies an address and queues what the monitor must see
    task automatic lookup(int dut, logic [35:0] a, logic c, logic h,
                          logic [7:0] cs, logic [4:0] at, string req);
        exp_t e;
        @(negedge clk);
        if (dut == 0) a0 = a; else a1 = a;
        coh = c;
        e.dut = dut; e.hit = h; e.cs = cs; e.attr = at; e.req = req;
        q.push_back(e);
        @(posedge clk);
        #2;
    endtask

    // monitor: one cycle after the address, compare registered outputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.dut == 0) begin
                    chk({e.req, " hit"},  hit0, e.hit);
                    chk({e.req, " cs"},   cs0,  e.cs);
                    chk({e.req, " attr"}, at0,  e.attr);
                end else begin
                    chk({e.req, " hit"},  hit1, e.hit);
                    chk({e.req, " cs"},   cs1,  e.cs);
                    chk({e.req, " attr"}, at1,  e.attr);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 hit0", hit0, 0);
        chk("R1 cnt0", cnt0, 0);
        chk("R1 lst0", lst0, 0);
        chk("R1 cnt1", cnt1, 0);
        rd(0, 8'h00, 32'h0, "R1 base0 read");
        rd(0, 8'h04, 32'h0, "R1 size0 read");
        rd(1, 8'h00, 32'h0, "R1 map0 read");
        lookup(0, 36'h0, 1'b0, 1'b0, 8'h00, 5'h00, "R1 lookup after reset");

        // R2 masking of unlisted bits
        wr(0, 8'h00, 32'h00AB_CDE0);
        rd(0, 8'h00, 32'h0, "R2 base mask");
        wr(0, 8'h0C, 32'h0F12_3409);
        rd(0, 8'h0C, 32'h0F00_0009, "R2 size mask");
        // program windows
        wr(0, 8'h04, 32'h0F00_0001);            // w0: 0..256M, cs0
        wr(0, 8'h08, 32'h1000_0000);            // w1 base 256M, cs2
        wr(0, 8'h10, 32'h0000_0001);            // w2 base 4G
        wr(0, 8'h14, 32'h0000_0005);            // w2 16M, cs1
        wr(0, 8'h18, 32'h0800_0000);            // w3 base 128M
        wr(0, 8'h1C, 32'h0700_000D);            // w3 128M, cs3
        // R2 unmapped offsets
        wr(0, 8'h20, 32'hFFFF_FFFF);
        rd(0, 8'h20, 32'h0, "R2 unmapped read");
        rd(0, 8'h02, 32'h0, "R2 unaligned read");
        rd(0, 8'h10, 32'h0000_0001, "R2 base2 read");

        // R8 usable summary: windows 0,1,3
        @(negedge clk); #1;
        chk("R8 cnt", cnt0, 3);
        chk("R8 list", lst0, 8'h34);

        // R3 R4 R5 R6 R7 lookups
        lookup(0, 36'h0_0000_0000, 0, 1, 8'h01, 5'h0E, "R3 w0 base");
        lookup(0, 36'h0_0FFF_FFFF, 0, 1, 8'h01, 5'h0E, "R4 overlap low index");
        lookup(0, 36'h0_1000_0000, 0, 1, 8'h04, 5'h0D, "R5 w1 cs2");
        lookup(0, 36'h0_1FFF_FFFF, 0, 1, 8'h04, 5'h0D, "R3 w1 top");
        lookup(0, 36'h0_2000_0000, 0, 0, 8'h00, 5'h00, "R3 w1 end miss");
        lookup(0, 36'h1_0000_0000, 0, 1, 8'h02, 5'h0B, "R3 high base");
        lookup(0, 36'h1_00FF_FFFF, 0, 1, 8'h02, 5'h0B, "R3 high top");
        lookup(0, 36'h1_0100_0000, 0, 0, 8'h00, 5'h00, "R3 high end miss");
        lookup(0, 36'h0_1000_0000, 1, 1, 8'h04, 5'h1D, "R6 coherent bit");
        lookup(0, 36'h0_0800_0000, 0, 1, 8'h01, 5'h0E, "R7 address change");

        // disable w0: w3 now owns the overlap
        wr(0, 8'h04, 32'h0);
        lookup(0, 36'h0_0800_0000, 0, 1, 8'h08, 5'h07, "R4 w3 after disable");
        lookup(0, 36'h0_0000_0000, 0, 0, 8'h00, 5'h00, "R3 disabled miss");
        @(negedge clk); #1;
        chk("R8 cnt after disable", cnt0, 2);
        chk("R8 list after disable", lst0, 8'h0D);

        // R9 packed style
        wr(1, 8'h00, 32'h004C_FF01);
        rd(1, 8'h00, 32'h000C_0001, "R9 map mask");
        wr(1, 8'h10, 32'h1084_0001);
        wr(1, 8'h08, 32'hFFFF_FFFF);
        rd(1, 8'h08, 32'h0, "R9 unmapped read");
        rd(1, 8'h10, 32'h1084_0001, "R9 map1 read");
        lookup(1, 36'h0_0FFF_FFFF, 0, 1, 8'h01, 5'h00, "R9 w0 top");
        lookup(1, 36'h0_1000_0000, 0, 0, 8'h00, 5'h00, "R9 w0 end miss");
        lookup(1, 36'h0_1080_0000, 1, 1, 8'h02, 5'h00, "R9 w1 attr zero");
        lookup(1, 36'h0_108F_FFFF, 0, 1, 8'h02, 5'h00, "R9 w1 top");
        lookup(1, 36'h0_1090_0000, 0, 0, 8'h00, 5'h00, "R9 w1 end miss");
        lookup(1, 36'h1_0000_0000, 0, 0, 8'h00, 5'h00, "R9 above 4G miss");
        @(negedge clk); #1;
        chk("R8 packed cnt", cnt1, 2);
        chk("R8 packed list", lst1, 8'h04);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule